// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single memory access may proceed. It holds sixteen protection entries. Each entry has an 8-bit configuration byte and a 32-bit word-granular address register. Every request is compared against those entries, and the block returns a grant or deny verdict. A request carries a byte address, a length of 1, 2 or 4 bytes, an access kind (read, write or fetch) and the privilege of the requester (machine or user).

Entries are loaded through a one-beat write port. The port writes either one of the four configuration words, each holding four entry bytes, or one of the sixteen address registers. An entry can describe a region in three ways: as an open-ended span bounded by its neighbour's address, as one aligned 4-byte word, or as an aligned power-of-two block. The lowest-numbered enabled entry that wholly contains the access decides the verdict. The verdict is registered and appears one clock after the request, together with a one-cycle valid strobe.

Top module: `pmp_checker`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_grant` are 0 and every entry is off, so a user access is granted.
- R2: `rsp_valid` is 1 in the cycle after `req_valid` is 1 and is 0 in the cycle after `req_valid` is 0. The verdict for a request is presented together with that strobe.
- R3: A write with `csr_is_addr`=0 and `csr_idx`=k (k<4) loads configuration word k. Entry i uses byte i%4 of word i/4, with R at bit 0, W at bit 1, X at bit 2, mode at bits 4:3 (0 off, 1 range, 2 4-byte, 3 power-of-two) and lock at bit 7. A write with `csr_is_addr`=1 loads the address register of entry `csr_idx`, which holds byte-address bits 33:2.
- R4: In range mode, entry i matches when the first word of the access is at or above the address register of entry i-1 (zero for entry 0) and the last word is below the address register of entry i. A lower bound at or above the upper bound matches nothing.
- R5: In 4-byte mode, the entry matches only when both the first and the last word equal its address register.
- R6: In power-of-two mode, the number of trailing ones n in the address register makes the low n word bits don't-care. The entry matches when both words agree with the register on all other bits.
- R7: The first word is addr>>2 and the last word is (addr+len-1)>>2. An access that lies only partly inside a region does not match that region.
- R8: When several enabled entries match, the one with the lowest index alone decides the verdict.
- R9: On a match, a machine-privilege access to an entry whose lock bit is clear is granted. With the lock set, the entry's permission bits apply to machine accesses as well.
- R10: Otherwise a matched access is granted only when the entry's bit for its kind is set: R for read (`req_type`=0), W for write (1) and X for fetch (2).
- R11: With no match, the access is granted when no entry is enabled or when the privilege is machine, and is denied otherwise.
- R12: `rsp_grant` keeps its value in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the entry registers |
| csr_is_addr | input | 1 | 1 selects an address register, 0 a configuration word |
| csr_idx | input | 4 | Register index |
| csr_wdata | input | 32 | Write data |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Byte address of the access |
| req_len | input | 3 | Access length in bytes (1, 2 or 4) |
| req_type | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | 1 machine, 0 user |
| rsp_valid | output | 1 | Verdict strobe, one cycle after the request |
| rsp_grant | output | 1 | 1 grant, 0 deny |

## Verification
The assertions assume that `req_len` is 1, 2 or 4 and that `req_type` never takes the value 3. They also assume that the write port is idle while a request is being evaluated, so the verdict reflects settled entry contents. The bench drives only those lengths and kinds, and it finishes every register write before issuing the requests that depend on it. Requests are separated by idle cycles, which also exercises the hold behaviour of the verdict register.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
    localparam int ENTRIES = 16;
    localparam int AW      = 32;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] spare;
        mode_e      mode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    typedef struct packed {
        logic valid;
        logic grant;
    } rsp_t;
endpackage

// File: rtl/pmp_cfg_regs.sv
module pmp_cfg_regs
    import pmp_chk_pkg::*;
#(
    parameter int N     = ENTRIES,
    parameter int W     = AW,
    parameter int IDXW  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_is_addr,
    input  logic [IDXW-1:0]   wr_index,
    input  logic [W-1:0]      wr_data,
    output cfg_t              cfg_o  [N],
    output logic [W-1:0]      addr_o [N],
    output logic              any_active_o
);
    localparam int PER_WORD = W / 8;
    localparam int NCFG     = (N + PER_WORD - 1) / PER_WORD;

    typedef struct packed {
        logic [NCFG-1:0][W-1:0] cfg;
        logic [N-1:0][W-1:0]    addr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_is_addr) begin
                if (int'(wr_index) < N) regs_d.addr[wr_index] = wr_data;
            end else begin
                if (int'(wr_index) < NCFG) regs_d.cfg[wr_index] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign cfg_o[i]  = cfg_t'(regs_q.cfg[i / PER_WORD][8*(i % PER_WORD) +: 8]);
        assign addr_o[i] = regs_q.addr[i];
    end

    always_comb begin
        any_active_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cfg_o[i].mode != MODE_OFF) any_active_o = 1'b1;
        end
    end

    // R3: address write lands in the selected register
    p_addr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_is_addr) |=> (addr_o[$past(wr_index)] == $past(wr_data)));

    // R3: configuration word 0 byte 0 feeds entry 0
    p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_is_addr && wr_index == '0) |=> (cfg_o[0] == cfg_t'($past(wr_data[7:0]))));
endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
    import pmp_chk_pkg::*;
#(
    parameter int W = AW
) (
    input  mode_e          mode,
    input  logic [W-1:0]   base_w,
    input  logic [W-1:0]   top_w,
    input  logic [W-1:0]   lo_w,
    input  logic [W-1:0]   hi_w,
    output logic           hit
);
    logic [W-1:0] care_mask;

    always_comb begin
        care_mask = ~(top_w & ~(top_w + 1'b1));
        unique case (mode)
            MODE_TOR:   hit = (lo_w >= base_w) && (hi_w < top_w);
            MODE_NA4:   hit = (lo_w == top_w) && (hi_w == top_w);
            MODE_NAPOT: hit = (((lo_w ^ top_w) & care_mask) == '0) &&
                              (((hi_w ^ top_w) & care_mask) == '0);
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    hits,
    output logic            found,
    output logic [IDXW-1:0] sel
);
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                sel   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_chk_pkg::*;
#(
    parameter int N    = ENTRIES,
    parameter int W    = AW,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic            csr_is_addr,
    input  logic [IDXW-1:0] csr_idx,
    input  logic [W-1:0]    csr_wdata,
    input  logic            req_valid,
    input  logic [W-1:0]    req_addr,
    input  logic [2:0]      req_len,
    input  logic [1:0]      req_type,
    input  logic            req_priv,
    output logic            rsp_valid,
    output logic            rsp_grant
);
    cfg_t             cfg   [N];
    logic [W-1:0]     addr  [N];
    logic             any_active;
    logic [N-1:0]     hits;
    logic             found;
    logic [IDXW-1:0]  sel;
    logic [W-1:0]     lo_w, hi_w;
    logic [W:0]       last_byte;
    cfg_t             sel_cfg;
    logic             perm_ok;
    rsp_t             rsp_d, rsp_q;

    pmp_cfg_regs #(.N(N), .W(W), .IDXW(IDXW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (csr_we),
        .wr_is_addr   (csr_is_addr),
        .wr_index     (csr_idx),
        .wr_data      (csr_wdata),
        .cfg_o        (cfg),
        .addr_o       (addr),
        .any_active_o (any_active)
    );

    assign lo_w      = {2'b00, req_addr[W-1:2]};
    assign last_byte = {1'b0, req_addr} + {{(W-2){1'b0}}, req_len} - 1'b1;
    assign hi_w      = {1'b0, last_byte[W:2]};

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [W-1:0] base_w;
        logic         raw_hit;
        if (i == 0) begin : g_first
            assign base_w = '0;
        end else begin : g_rest
            assign base_w = addr[i-1];
        end

        pmp_entry_match #(.W(W)) u_match (
            .mode   (cfg[i].mode),
            .base_w (base_w),
            .top_w  (addr[i]),
            .lo_w   (lo_w),
            .hi_w   (hi_w),
            .hit    (raw_hit)
        );
        assign hits[i] = raw_hit;

        // R4: an empty range never matches
        p_tor_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[i].mode == MODE_TOR && base_w >= addr[i]) |-> !hits[i]);
        // R5: a 4-byte hit means the access starts on the entry's word
        p_na4_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hits[i] && cfg[i].mode == MODE_NA4) |-> (lo_w == addr[i]));
        // R7: a matched access never ends before it starts
        p_span_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && hits[i]) |-> (hi_w >= lo_w));
    end

    pmp_prio_pick #(.N(N), .IDXW(IDXW)) u_pick (
        .hits  (hits),
        .found (found),
        .sel   (sel)
    );

    assign sel_cfg = cfg[sel];

    always_comb begin
        unique case (acc_e'(req_type))
            ACC_READ:  perm_ok = sel_cfg.r;
            ACC_WRITE: perm_ok = sel_cfg.w;
            ACC_FETCH: perm_ok = sel_cfg.x;
            default:   perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (found) rsp_d.grant = (req_priv && !sel_cfg.lock) || perm_ok;
            else       rsp_d.grant = !any_active || req_priv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_grant = rsp_q.grant;

    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_hold_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_grant));
    p_all_off_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_active) |=> rsp_grant);
    p_machine_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && found && !sel_cfg.lock) |=> rsp_grant);
    p_type_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_type != 2'd3));
endmodule

// File: tb/sim_pmp_checker.sv
module sim_pmp_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic        csr_is_addr = 1'b0;
    logic [3:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_len = 3'd4;
    logic [1:0]  req_type = 2'd0;
    logic        req_priv = 1'b0;
    logic        rsp_valid, rsp_grant;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;
    localparam logic M = 1'b1, U = 1'b0;

    always #2 clk = ~clk;

    pmp_checker u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_is_addr(csr_is_addr),
        .csr_idx(csr_idx), .csr_wdata(csr_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_len(req_len), .req_type(req_type),
        .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic is_addr, input int idx, input logic [31:0] data);
        @(negedge clk);
        csr_we = 1'b1; csr_is_addr = is_addr; csr_idx = 4'(idx); csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < 4; k++) wr(1'b0, k, 32'h0);
    endtask

    task automatic acc(input logic [31:0] a, input int len, input logic [1:0] t,
                       input logic p, input logic exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = 3'(len); req_type = t; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid, 1'b1, {tag, " strobe R2"});
        check(rsp_grant, exp, tag);
    endtask

    task automatic t_reset();
        check(rsp_valid, 1'b0, "R1 valid after reset");
        check(rsp_grant, 1'b0, "R1 grant after reset");
        acc(32'h100, 4, RD, U, 1'b1, "R1 all off user read");
        acc(32'h100, 4, WR, U, 1'b1, "R11 no entry enabled");
    endtask

    task automatic t_tor();
        clear_cfg();
        wr(1'b1, 0, 32'h400);
        wr(1'b0, 0, 32'h0000_0009);
        acc(32'h0FFC, 4, RD, U, 1'b1, "R4 entry0 below top");
        acc(32'h0FFC, 4, WR, U, 1'b0, "R10 no W bit");
        acc(32'h1000, 4, RD, U, 1'b0, "R4 top exclusive / R11 user deny");
        acc(32'h1000, 4, RD, M, 1'b1, "R11 machine no match");
        acc(32'h0FFE, 4, RD, U, 1'b0, "R7 partial overlap");
        acc(32'h0FFE, 2, RD, U, 1'b1, "R7 last word inside");
        wr(1'b1, 1, 32'h800);
        wr(1'b0, 0, 32'h0000_0900);
        acc(32'h1000, 4, RD, U, 1'b1, "R4 entry1 lower bound");
        acc(32'h0FFC, 4, RD, U, 1'b0, "R4 below base");
        wr(1'b1, 0, 32'h900);
        acc(32'h2100, 4, RD, U, 1'b0, "R4 empty range");
    endtask

    task automatic t_na4();
        clear_cfg();
        wr(1'b1, 1, 32'h800);
        wr(1'b0, 0, 32'h0000_1200);
        acc(32'h2000, 4, WR, U, 1'b1, "R5 exact word");
        acc(32'h2002, 2, WR, U, 1'b1, "R5 half inside");
        acc(32'h2004, 1, WR, U, 1'b0, "R5 next word");
        acc(32'h2000, 4, FE, U, 1'b0, "R10 no X bit");
        acc(32'h2003, 2, WR, U, 1'b0, "R7 straddles word");
    endtask

    task automatic t_napot();
        clear_cfg();
        wr(1'b1, 5, 32'h101F);
        wr(1'b0, 1, 32'h0000_1C00);
        acc(32'h407C, 4, FE, U, 1'b1, "R6 top of block");
        acc(32'h4000, 1, FE, U, 1'b1, "R6 base of block");
        acc(32'h4080, 4, FE, U, 1'b0, "R6 past block");
        acc(32'h3FFE, 4, FE, U, 1'b0, "R7 partial start");
        acc(32'h4000, 4, RD, U, 1'b0, "R10 no R bit");
        acc(32'h4000, 4, RD, M, 1'b1, "R9 machine unlocked");
        wr(1'b0, 1, 32'h0000_9C00);
        acc(32'h4000, 4, RD, M, 1'b0, "R9 machine locked");
        acc(32'h4000, 4, FE, M, 1'b1, "R9 locked X applies");
    endtask

    task automatic t_prio();
        clear_cfg();
        wr(1'b1, 2, 32'hC00);
        wr(1'b1, 3, 32'hC01);
        wr(1'b0, 0, 32'h1B11_0000);
        acc(32'h3000, 4, WR, U, 1'b0, "R8 lower entry wins");
        acc(32'h3004, 4, WR, U, 1'b1, "R8 second entry");
        acc(32'h3000, 4, RD, U, 1'b1, "R8 read both");
    endtask

    task automatic t_hold();
        acc(32'h3004, 4, WR, U, 1'b1, "R12 setup");
        @(negedge clk);
        check(rsp_valid, 1'b0, "R2 idle strobe low");
        check(rsp_grant, 1'b1, "R12 grant held");
        acc(32'h3000, 4, WR, U, 1'b0, "R12 setup deny");
        @(negedge clk);
        @(negedge clk);
        check(rsp_grant, 1'b0, "R12 deny held");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tor();
        t_na4();
        t_napot();
        t_prio();
        t_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule